// File: doc/BRIEF.md
# Gapped Clock Super-Pattern Generator

This block runs from a 51.84 MHz reference clock and produces a gapped clock enable like the one a SONET-to-DS3 demapper hands to a line interface. The enable is a one-cycle pulse that marks a reference cycle carrying a DS3 bit. It is grouped into windows of 720 reference cycles. Two kinds of window exist: kind A carries 621 pulses and kind B carries 622. They repeat in the fixed order A, A, B with no idle cycles between them. One such super pattern lasts 2160 reference periods, which is about 41.667 µs, and holds 1864 pulses. Over time this gives exactly the DS3 rate.

Inside each window, an accumulator spreads the pulses as evenly as it can. Each active cycle it adds the window's pulse count to the accumulator. When the sum reaches the window length, it raises the pulse and subtracts the window length. The accumulator and the cycle counter reload at every window boundary.

The block also carries a serial data bit from a system-side input to its output, taking a new bit only on pulse cycles. A `run` input freezes the whole generator when low. Outputs are registered, so each appears one clock after the edge that sampled its inputs.

Top module: `gapped_clk_pattern_gen`

## Requirements
- R1: While reset is high, and at the first sample after it, `gap_en_o`, `super_start_o`, `data_o` and `sub_idx_o` are all 0. The first active cycle after reset is cycle 0 of the first A window.
- R2: Every window spans exactly WIN_LEN active cycles (default 720), and `sub_idx_o` stays constant for all of them.
- R3: Each A window (index 0 or 1) holds exactly CNT_A pulses (default 621).
- R4: The B window (index NUM_A, default 2) holds exactly CNT_B pulses (default 622).
- R5: `sub_idx_o` follows 0, 1, …, NUM_A and then wraps to 0 back to back. Values 0 to NUM_A-1 denote A windows and NUM_A denotes the B window.
- R6: One super pattern spans WIN_LEN×(NUM_A+1) active cycles (default 2160) and holds NUM_A×CNT_A+CNT_B pulses (default 1864).
- R7: At active cycle c (counted from 0) of a window with N pulses, a pulse is emitted if and only if floor((c+1)·N/WIN_LEN) > floor(c·N/WIN_LEN). Cycle 0 therefore never carries a pulse.
- R8: `super_start_o` is high for exactly one sample, the one for cycle 0 of window index 0, and at no other time.
- R9: When `run` is low, no pulse and no start marker are produced. The position in the pattern does not advance, and `sub_idx_o` and `data_o` hold their values.
- R10: On a pulse, `data_o` takes the `ser_in` value sampled at that edge. In every other cycle it holds its value.
- R11: All outputs are registered. Each reflects the inputs sampled at the preceding rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (51.84 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Advance enable; low freezes the generator |
| ser_in | input | 1 | Serial data bit from the system side |
| gap_en_o | output | 1 | Gapped clock enable / data valid strobe |
| data_o | output | 1 | Serial data, updated only on pulse cycles |
| sub_idx_o | output | clog2(NUM_A+1) | Current window index (0..NUM_A−1 = A, NUM_A = B) |
| super_start_o | output | 1 | One-cycle marker for the first cycle of a super pattern |

## Verification
The assertions assume that `rst` is held for at least one edge before any property is meaningful. They also assume that `run` and `ser_in` are stable around the rising edge, since every property is stated relative to the previous sample of `run` or `rst`. The stimulus changes `run`, `ser_in` and `rst` only on the falling edge. It drops `run` on a pseudo-random subset of cycles and asserts reset once in the middle of a pattern, so the freeze and restart behaviour is covered. Two instances receive identical stimulus: the default 720/621/622 configuration and a 12-cycle window with 7/8 pulses. The smaller one wraps through many super patterns.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    // Width needed to hold values 0..n-1 (never below one bit)
    function automatic int unsigned gcp_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    typedef struct packed {
        logic gap_en;
        logic start;
    } gcp_flag_t;

endpackage

// File: rtl/gcp_seq.sv
module gcp_seq
    import gcp_pkg::*;
#(
    parameter int unsigned WIN_LEN = 720,
    parameter int unsigned SUB_CNT = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        step,
    output logic [gcp_w(SUB_CNT)-1:0]   sub_o,
    output logic                        win_last_o,
    output logic                        sup_first_o,
    output logic                        is_b_o
);
    localparam int unsigned CW = gcp_w(WIN_LEN);
    localparam int unsigned SW = gcp_w(SUB_CNT);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [SW-1:0] sub;
    } seq_t;

    seq_t s_d, s_q;
    logic last_cyc;
    logic last_sub;

    always_comb begin
        last_cyc = (s_q.cyc == CW'(WIN_LEN - 1));
        last_sub = (s_q.sub == SW'(SUB_CNT - 1));
        s_d      = s_q;
        if (step) begin
            if (last_cyc) begin
                s_d.cyc = '0;
                s_d.sub = last_sub ? '0 : s_q.sub + SW'(1);
            end else begin
                s_d.cyc = s_q.cyc + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sub_o       = s_q.sub;
    assign win_last_o  = last_cyc;
    assign sup_first_o = (s_q.cyc == '0) && (s_q.sub == '0);
    assign is_b_o      = last_sub;

endmodule

// File: rtl/gcp_accum.sv
module gcp_accum
    import gcp_pkg::*;
#(
    parameter int unsigned WIN_LEN = 720,
    parameter int unsigned CNT_A   = 621,
    parameter int unsigned CNT_B   = 622
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic is_b,
    input  logic win_last,
    output logic fire_o
);
    // The sum reaches at most 2*WIN_LEN-2
    localparam int unsigned AW = gcp_w(2 * WIN_LEN);

    typedef struct packed {
        logic [AW-1:0] acc;
    } acc_t;

    acc_t a_d, a_q;
    logic [AW-1:0] inc;
    logic          fire;

    always_comb begin
        inc  = a_q.acc + (is_b ? AW'(CNT_B) : AW'(CNT_A));
        fire = (inc >= AW'(WIN_LEN));
        a_d  = a_q;
        if (step) begin
            if (win_last) begin
                a_d.acc = '0;
            end else if (fire) begin
                a_d.acc = inc - AW'(WIN_LEN);
            end else begin
                a_d.acc = inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign fire_o = fire;

endmodule

// File: rtl/gcp_outreg.sv
module gcp_outreg
    import gcp_pkg::*;
#(
    parameter int unsigned SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          fire,
    input  logic          sup_first,
    input  logic [SW-1:0] sub_in,
    input  logic          ser_in,
    output logic          gap_en_o,
    output logic          start_o,
    output logic [SW-1:0] sub_o,
    output logic          data_o
);
    typedef struct packed {
        gcp_flag_t     flag;
        logic [SW-1:0] sub;
        logic          data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d             = o_q;
        o_d.flag.gap_en = step && fire;
        o_d.flag.start  = step && sup_first;
        if (step) begin
            o_d.sub = sub_in;
            if (fire) begin
                o_d.data = ser_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign gap_en_o = o_q.flag.gap_en;
    assign start_o  = o_q.flag.start;
    assign sub_o    = o_q.sub;
    assign data_o   = o_q.data;

endmodule

// File: rtl/gapped_clk_pattern_gen.sv
module gapped_clk_pattern_gen
    import gcp_pkg::*;
#(
    parameter int unsigned WIN_LEN = 720,
    parameter int unsigned CNT_A   = 621,
    parameter int unsigned CNT_B   = 622,
    parameter int unsigned NUM_A   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic                       ser_in,
    output logic                       gap_en_o,
    output logic                       data_o,
    output logic [gcp_w(NUM_A+1)-1:0]  sub_idx_o,
    output logic                       super_start_o
);
    localparam int unsigned SUB_CNT = NUM_A + 1;
    localparam int unsigned SW      = gcp_w(SUB_CNT);

    logic [SW-1:0] sub;
    logic          win_last;
    logic          sup_first;
    logic          is_b;
    logic          fire;

    gcp_seq #(
        .WIN_LEN (WIN_LEN),
        .SUB_CNT (SUB_CNT)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .step        (run),
        .sub_o       (sub),
        .win_last_o  (win_last),
        .sup_first_o (sup_first),
        .is_b_o      (is_b)
    );

    gcp_accum #(
        .WIN_LEN (WIN_LEN),
        .CNT_A   (CNT_A),
        .CNT_B   (CNT_B)
    ) accum_i (
        .clk      (clk),
        .rst      (rst),
        .step     (run),
        .is_b     (is_b),
        .win_last (win_last),
        .fire_o   (fire)
    );

    gcp_outreg #(
        .SW (SW)
    ) outreg_i (
        .clk       (clk),
        .rst       (rst),
        .step      (run),
        .fire      (fire),
        .sup_first (sup_first),
        .sub_in    (sub),
        .ser_in    (ser_in),
        .gap_en_o  (gap_en_o),
        .start_o   (super_start_o),
        .sub_o     (sub_idx_o),
        .data_o    (data_o)
    );

endmodule

// File: rtl/gapped_clk_pattern_chk.sv
module gapped_clk_pattern_chk
    import gcp_pkg::*;
#(
    parameter int unsigned WIN_LEN = 720,
    parameter int unsigned CNT_A   = 621,
    parameter int unsigned CNT_B   = 622,
    parameter int unsigned NUM_A   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic                       gap_en_o,
    input  logic                       data_o,
    input  logic [gcp_w(NUM_A+1)-1:0]  sub_idx_o,
    input  logic                       super_start_o
);
    localparam int unsigned SW    = gcp_w(NUM_A + 1);
    localparam int unsigned TOTAL = NUM_A * CNT_A + CNT_B;

    logic [31:0] pcnt_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            seen_q <= 1'b0;
        end else if (super_start_o) begin
            pcnt_q <= '0;
            seen_q <= 1'b1;
        end else begin
            pcnt_q <= pcnt_q + {31'd0, gap_en_o};
        end
    end

    assert_pulse_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
        gap_en_o |-> $past(run));

    assert_start_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
        super_start_o |-> $past(run));

    assert_hold_in_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (!gap_en_o && !$past(rst)) |-> $stable(data_o));

    assert_start_first_a_R8: assert property (@(posedge clk) disable iff (rst)
        super_start_o |-> (sub_idx_o == '0));

    assert_no_pulse_at_start_R7: assert property (@(posedge clk) disable iff (rst)
        super_start_o |-> !gap_en_o);

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
        sub_idx_o <= SW'(NUM_A));

    assert_idx_order_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sub_idx_o != $past(sub_idx_o))) |->
        (sub_idx_o == (($past(sub_idx_o) == SW'(NUM_A)) ? '0 : $past(sub_idx_o) + SW'(1))));

    assert_super_total_R6: assert property (@(posedge clk) disable iff (rst)
        (super_start_o && seen_q) |-> (pcnt_q == TOTAL));

endmodule

bind gapped_clk_pattern_gen gapped_clk_pattern_chk #(
    .WIN_LEN (WIN_LEN),
    .CNT_A   (CNT_A),
    .CNT_B   (CNT_B),
    .NUM_A   (NUM_A)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .run           (run),
    .gap_en_o      (gap_en_o),
    .data_o        (data_o),
    .sub_idx_o     (sub_idx_o),
    .super_start_o (super_start_o)
);

// File: tb/gapped_clk_pattern_gen_tb.sv
module gapped_clk_pattern_gen_tb_top;

    localparam int NDUT = 2;
    localparam int W0 = 720, A0 = 621, B0 = 622, K0 = 2;
    localparam int W1 = 12,  A1 = 7,   B1 = 8,   K1 = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic ser = 1'b0;

    logic       en0, st0, dat0;
    logic [1:0] idx0;
    logic       en1, st1, dat1;
    logic [1:0] idx1;

    always #4 clk = ~clk;

    gapped_clk_pattern_gen #(.WIN_LEN(W0), .CNT_A(A0), .CNT_B(B0), .NUM_A(K0)) dut_i (
        .clk(clk), .rst(rst), .run(run), .ser_in(ser),
        .gap_en_o(en0), .data_o(dat0), .sub_idx_o(idx0), .super_start_o(st0)
    );

    gapped_clk_pattern_gen #(.WIN_LEN(W1), .CNT_A(A1), .CNT_B(B1), .NUM_A(K1)) dut_s (
        .clk(clk), .rst(rst), .run(run), .ser_in(ser),
        .gap_en_o(en1), .data_o(dat1), .sub_idx_o(idx1), .super_start_o(st1)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int cfg_w[NDUT], cfg_a[NDUT], cfg_b[NDUT], cfg_k[NDUT];
    int t[NDUT];
    bit e_en[NDUT], e_st[NDUT], e_dat[NDUT];
    int e_idx[NDUT];
    int win_cnt[NDUT], sup_cnt[NDUT];
    bit chk_win[NDUT], chk_sup[NDUT];
    int exp_win[NDUT];
    bit was_run;
    logic [15:0] lfsr = 16'hACE1;

    function automatic bit fire_at(int c, int n, int w);
        return ((c + 1) * n) / w > (c * n) / w;
    endfunction

    task automatic check(string req, int d, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s dut%0d t=%0t actual=%0d expected=%0d", req, d, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int d = 0; d < NDUT; d++) begin
            t[d] = 0; e_en[d] = 0; e_st[d] = 0; e_dat[d] = 0; e_idx[d] = 0;
            win_cnt[d] = 0; sup_cnt[d] = 0; chk_win[d] = 0; chk_sup[d] = 0;
        end
    endtask

    task automatic model_step(int d, bit r, bit s);
        int per, p, sub, c, n;
        bit f;
        if (!r) begin
            e_en[d] = 0;
            e_st[d] = 0;
            return;
        end
        per = cfg_w[d] * (cfg_k[d] + 1);
        p   = t[d] % per;
        sub = p / cfg_w[d];
        c   = p % cfg_w[d];
        n   = (sub == cfg_k[d]) ? cfg_b[d] : cfg_a[d];
        f   = fire_at(c, n, cfg_w[d]);
        e_en[d]  = f;
        e_st[d]  = (p == 0);
        e_idx[d] = sub;
        if (f) e_dat[d] = s;
        if (c == cfg_w[d] - 1) begin
            chk_win[d] = 1;
            exp_win[d] = n;
            if (sub == cfg_k[d]) chk_sup[d] = 1;
        end
        t[d]++;
    endtask

    task automatic compare_all(bit r);
        logic en, st, dat;
        int idx;
        string tag;
        for (int d = 0; d < NDUT; d++) begin
            en  = (d == 0) ? en0 : en1;
            st  = (d == 0) ? st0 : st1;
            dat = (d == 0) ? dat0 : dat1;
            idx = (d == 0) ? int'(idx0) : int'(idx1);
            // R11: expectations were formed from inputs sampled at the preceding edge
            tag = r ? "" : " R9";
            check({"R7 gap enable", tag}, d, int'(en), int'(e_en[d]));
            check({"R8 start marker", tag}, d, int'(st), int'(e_st[d]));
            check({"R2 R5 window index", tag}, d, idx, e_idx[d]);
            check({"R10 data", tag}, d, int'(dat), int'(e_dat[d]));
            win_cnt[d] += int'(en);
            sup_cnt[d] += int'(en);
            if (chk_win[d]) begin
                check(exp_win[d] == cfg_b[d] ? "R4 B window pulse count" : "R3 A window pulse count",
                      d, win_cnt[d], exp_win[d]);
                win_cnt[d] = 0;
                chk_win[d] = 0;
            end
            if (chk_sup[d]) begin
                check("R6 super pattern pulse total", d, sup_cnt[d], cfg_k[d] * cfg_a[d] + cfg_b[d]);
                sup_cnt[d] = 0;
                chk_sup[d] = 0;
            end
        end
    endtask

    task automatic check_reset();
        check("R1 reset gap enable", 0, int'(en0), 0);
        check("R1 reset start", 0, int'(st0), 0);
        check("R1 reset index", 0, int'(idx0), 0);
        check("R1 reset data", 0, int'(dat0), 0);
        check("R1 reset gap enable", 1, int'(en1), 0);
        check("R1 reset index", 1, int'(idx1), 0);
        check("R1 reset data", 1, int'(dat1), 0);
    endtask

    task automatic run_cycles(int n, int idle_mask);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run  = ((lfsr[7:0] & idle_mask[7:0]) != 0) || (idle_mask == 0);
            ser  = lfsr[3];
            was_run = run;
            for (int d = 0; d < NDUT; d++) model_step(d, run, ser);
            @(negedge clk);
            compare_all(was_run);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run = 1'b1;
        ser = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        check_reset();
        rst = 1'b0;
    endtask

    initial begin
        cfg_w[0] = W0; cfg_a[0] = A0; cfg_b[0] = B0; cfg_k[0] = K0;
        cfg_w[1] = W1; cfg_a[1] = A1; cfg_b[1] = B1; cfg_k[1] = K1;
        @(negedge clk);
        do_reset();
        // continuous run: two full default super patterns, tight spacing check
        run_cycles(2 * 3 * W0 + 5, 0);
        // gapped run: run held low on a pseudo-random subset of cycles
        run_cycles(3000, 8'h07);
        // reset in the middle of a pattern, then restart from A
        do_reset();
        run_cycles(3 * W0 + 40, 8'h1F);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired at t=%0t actual=running expected=finished", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule